// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block is the control register and sequencing guard that sits in front of an embedded flash array. Software arms programming by setting a latch-enable bit. It then performs one or more ordinary array writes, which load the data and address programming latches. Finally it asks for the high-voltage enable, which drives the charge pump. The block refuses that request unless the sequence has been followed. While high voltage is applied it freezes the other control bits.

The block also steers CPU reads of the array. A read can return the addressed cell, the contents of the programming latches, or nothing at all. A read that returns nothing is an ignored cycle: the acknowledge is withheld and the data is zero. Pump timing, the cell model and erase-time counting belong elsewhere. The block only exports the pump enable, the erase/boot mode bits and the latched address and data.

Top module: `flash_pe_guard`

## Requirements
- R1: Reset clears latch-enable, erase-select, high-voltage enable and the latches-written flag. Boot-protect resets to parameter BOOT_RST (default 1). With defaults, regRdData reads 4'b0100 and pumpEn is 0.
- R2: The control register fields are latch-enable at bit 0, erase-select at bit 1, boot-protect at bit 2 and high-voltage enable at bit 3. While high voltage is off, a register write loads bits 0 to 2 directly. regRdData, eraseMode and bootProt show the stored values in the cycle after the write.
- R3: A write with bit 3 set turns on high voltage only when three conditions hold at that write: latch-enable is already 1, the latches-written flag is set, and the written bit 0 is 1. Otherwise bit 3 reads back 0. pumpEn equals bit 3.
- R4: The latches-written flag is cleared by a write that takes latch-enable from 0 to 1. It is set by an array write while latch-enable is 1 and high voltage is off. Until the flag is set again, a high-voltage request is refused.
- R5: While high voltage is on, register writes leave bits 0 to 2 unchanged and update only bit 3. Writing 0 to bit 3 switches high voltage off.
- R6: A single write that sets bit 3 and clears bit 0 does not turn on high voltage.
- R7: With high voltage off, an array read returns cellRdData when latch-enable is 0. It also returns cellRdData when latch-enable and erase-select are both 1.
- R8: With high voltage off, latch-enable 1 and erase-select 0, an array read returns the latched data instead of the addressed cell.
- R9: With high voltage on, a read cycle is ignored: arrRdAck stays 0 and cpuRdData is all zero. Outside this state, arrRdAck follows arrRdEn.
- R10: The programming latches capture arrAddr and arrWrData only on an array write made while latch-enable is 1 and high voltage is off. Array writes at any other time leave progAddr and progData unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 4 | Control register write value |
| regRdData | output | 4 | Control register read value |
| arrRdEn | input | 1 | CPU array read strobe |
| arrWrEn | input | 1 | CPU array write strobe |
| arrAddr | input | ADDR_W | Array address |
| arrWrData | input | DATA_W | Array write data |
| cellRdData | input | DATA_W | Data read from the addressed cell |
| cpuRdData | output | DATA_W | Data returned to the CPU |
| arrRdAck | output | 1 | Read cycle accepted |
| pumpEn | output | 1 | Program/erase high-voltage enable |
| eraseMode | output | 1 | Erase selected |
| bootProt | output | 1 | Boot-protect bit |
| progAddr | output | ADDR_W | Latched program address |
| progData | output | DATA_W | Latched program data |

## Verification
The hardest state to reach is a refused high-voltage request in which latch-enable is already 1. Either the flag was cleared by a fresh 0-to-1 latch-enable edge and no array write has followed, or the same write drops latch-enable. To reach it, the stimulus first completes a full arm-and-write sequence. It then toggles latch-enable off and on again before requesting high voltage. After that it writes the latches once and requests high voltage with bit 0 cleared. A behavioural model in the bench tracks the flag as plain state. Every output is compared against it on each clock, so the refusals and the frozen-bit writes are seen as soon as they happen.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam int CTRL_W   = 4;
  localparam int BIT_LAT  = 0;
  localparam int BIT_ERAS = 1;
  localparam int BIT_BOOT = 2;
  localparam int BIT_HV   = 3;

  typedef enum logic [1:0] {
    RD_NORMAL = 2'd0,
    RD_LATCH  = 2'd1,
    RD_IGNORE = 2'd2
  } readPath_t;

  typedef struct packed {
    logic      latchLoad;
    readPath_t readPath;
  } dpStrobes_t;
endpackage

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter logic BOOT_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              arrWrEn,
  output logic [CTRL_W-1:0] regRdData,
  output logic              pumpEn,
  output logic              eraseMode,
  output logic              bootProt,
  output dpStrobes_t        strobes
);
  logic latchEn, eraseSel, bootBit, hvEn, written;
  logic latchRise, latchLoad, hvAccept;

  assign latchRise = regWrEn && !hvEn && !latchEn && regWrData[BIT_LAT];
  assign latchLoad = arrWrEn && latchEn && !hvEn;
  assign hvAccept  = regWrData[BIT_HV] && regWrData[BIT_LAT] && latchEn && written;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchEn  <= 1'b0;
      eraseSel <= 1'b0;
      bootBit  <= BOOT_RST;
      hvEn     <= 1'b0;
      written  <= 1'b0;
    end else begin
      if (regWrEn) begin
        if (hvEn) begin
          hvEn <= regWrData[BIT_HV];
        end else begin
          latchEn  <= regWrData[BIT_LAT];
          eraseSel <= regWrData[BIT_ERAS];
          bootBit  <= regWrData[BIT_BOOT];
          hvEn     <= hvAccept;
        end
      end
      if (latchRise)      written <= 1'b0;
      else if (latchLoad) written <= 1'b1;
    end
  end

  always_comb begin
    regRdData           = '0;
    regRdData[BIT_LAT]  = latchEn;
    regRdData[BIT_ERAS] = eraseSel;
    regRdData[BIT_BOOT] = bootBit;
    regRdData[BIT_HV]   = hvEn;
    strobes.latchLoad   = latchLoad;
    if (hvEn)                      strobes.readPath = RD_IGNORE;
    else if (latchEn && !eraseSel) strobes.readPath = RD_LATCH;
    else                           strobes.readPath = RD_NORMAL;
  end

  assign pumpEn    = hvEn;
  assign eraseMode = eraseSel;
  assign bootProt  = bootBit;

  AST_HV_NEEDS_ARMING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hvEn) |-> ($past(latchEn) && $past(written))); // R3
  AST_FLAG_CLEAR_ON_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchEn) |-> !written); // R4
  AST_BITS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(hvEn) |-> $stable({latchEn, eraseSel, bootBit})); // R5
  AST_NO_START_ON_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !hvEn && !regWrData[BIT_LAT]) |=> !hvEn); // R6
endmodule

// File: rtl/flash_pe_datapath.sv
module flash_pe_datapath
  import flash_pe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              arrRdEn,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic [DATA_W-1:0] arrWrData,
  input  logic [DATA_W-1:0] cellRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              arrRdAck,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAddr <= '0;
      progData <= '0;
    end else if (strobes.latchLoad) begin
      progAddr <= arrAddr;
      progData <= arrWrData;
    end
  end

  always_comb begin
    case (strobes.readPath)
      RD_LATCH:  cpuRdData = progData;
      RD_IGNORE: cpuRdData = '0;
      default:   cpuRdData = cellRdData;
    endcase
  end

  assign arrRdAck = arrRdEn && (strobes.readPath != RD_IGNORE);

  AST_IGNORED_READ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readPath == RD_IGNORE) |-> (cpuRdData == '0 && !arrRdAck)); // R9
  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchLoad |=> (progData == $past(arrWrData) && progAddr == $past(arrAddr))); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchLoad |=> ($stable(progData) && $stable(progAddr))); // R10
endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard
  import flash_pe_pkg::*;
#(
  parameter int   DATA_W   = 8,
  parameter int   ADDR_W   = 10,
  parameter logic BOOT_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regWrData,
  output logic [3:0]        regRdData,
  input  logic              arrRdEn,
  input  logic              arrWrEn,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic [DATA_W-1:0] arrWrData,
  input  logic [DATA_W-1:0] cellRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              arrRdAck,
  output logic              pumpEn,
  output logic              eraseMode,
  output logic              bootProt,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData
);
  dpStrobes_t strobes;

  flash_pe_ctrl #(.BOOT_RST(BOOT_RST)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .arrWrEn(arrWrEn), .regRdData(regRdData), .pumpEn(pumpEn),
    .eraseMode(eraseMode), .bootProt(bootProt), .strobes(strobes)
  );

  flash_pe_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .arrRdEn(arrRdEn),
    .arrAddr(arrAddr), .arrWrData(arrWrData), .cellRdData(cellRdData),
    .cpuRdData(cpuRdData), .arrRdAck(arrRdAck),
    .progAddr(progAddr), .progData(progData)
  );
endmodule

// File: tb/test_flash_pe_guard.sv
module test_flash_pe_guard;
  localparam int DW = 8;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regWrData = '0;
  logic [3:0] regRdData;
  logic arrRdEn = 1'b0, arrWrEn = 1'b0;
  logic [AW-1:0] arrAddr = '0;
  logic [DW-1:0] arrWrData = '0;
  logic [DW-1:0] cellRdData, cpuRdData, progData;
  logic [AW-1:0] progAddr;
  logic arrRdAck, pumpEn, eraseMode, bootProt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign cellRdData = arrAddr[DW-1:0] ^ 8'h3C;

  flash_pe_guard #(.DATA_W(DW), .ADDR_W(AW)) i_flash_pe_guard (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .arrRdEn(arrRdEn), .arrWrEn(arrWrEn),
    .arrAddr(arrAddr), .arrWrData(arrWrData), .cellRdData(cellRdData),
    .cpuRdData(cpuRdData), .arrRdAck(arrRdAck), .pumpEn(pumpEn),
    .eraseMode(eraseMode), .bootProt(bootProt),
    .progAddr(progAddr), .progData(progData)
  );

  // behavioural reference
  bit mLat, mEras, mBoot, mHv, mWritten;
  int mLatAddr, mLatData;

  always @(posedge clk) begin
    if (!rstN) begin
      mLat = 0; mEras = 0; mBoot = 1; mHv = 0; mWritten = 0;
      mLatAddr = 0; mLatData = 0;
    end else begin
      bit oLat, oHv, oWritten;
      oLat = mLat; oHv = mHv; oWritten = mWritten;
      if (arrWrEn && oLat && !oHv) begin
        mLatAddr = int'(arrAddr); mLatData = int'(arrWrData); mWritten = 1;
      end
      if (regWrEn) begin
        if (oHv) mHv = regWrData[3];
        else begin
          if (!oLat && regWrData[0]) mWritten = 0;
          mHv   = regWrData[3] && regWrData[0] && oLat && oWritten;
          mLat  = regWrData[0];
          mEras = regWrData[1];
          mBoot = regWrData[2];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      int expReg, expRd;
      string rdTag;
      expReg = {mHv, mBoot, mEras, mLat};
      if (mHv) begin expRd = 0; rdTag = "R9 read"; end
      else if (mLat && !mEras) begin expRd = mLatData; rdTag = "R8 read"; end
      else begin expRd = int'(cellRdData); rdTag = "R7 read"; end
      check(int'(regRdData) == expReg, "R2/R5 regRdData", int'(regRdData), expReg);
      check(pumpEn == mHv, "R3/R6 pumpEn", int'(pumpEn), int'(mHv));
      check(eraseMode == mEras && bootProt == mBoot, "R2 mode bits",
            int'({eraseMode, bootProt}), int'({mEras, mBoot}));
      check(int'(cpuRdData) == expRd, rdTag, int'(cpuRdData), expRd);
      check(arrRdAck == (arrRdEn && !mHv), "R9 arrRdAck", int'(arrRdAck), int'(arrRdEn && !mHv));
      check(int'(progData) == mLatData && int'(progAddr) == mLatAddr, "R10 latches",
            int'(progData), mLatData);
    end
  end

  task automatic regWrite(input logic [3:0] d);
    @(posedge clk); #2; regWrEn = 1'b1; regWrData = d;
    @(posedge clk); #2; regWrEn = 1'b0;
  endtask

  task automatic arrWrite(input int a, input int d);
    @(posedge clk); #2; arrWrEn = 1'b1; arrAddr = AW'(a); arrWrData = DW'(d);
    @(posedge clk); #2; arrWrEn = 1'b0;
  endtask

  task automatic arrRead(input int a);
    @(posedge clk); #2; arrRdEn = 1'b1; arrAddr = AW'(a);
    @(negedge clk);
  endtask

  task automatic idleRead();
    arrRdEn = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(regRdData == 4'b0100 && !pumpEn, "R1 reset", int'(regRdData), 4);

    regWrite(4'b0001);
    @(negedge clk);
    check(regRdData == 4'b0001, "R2 load bits", int'(regRdData), 1);
    arrRead(7);
    check(cpuRdData == 8'h00, "R8 unloaded latch read", int'(cpuRdData), 0);
    idleRead();

    regWrite(4'b1001);
    @(negedge clk);
    check(!pumpEn, "R4 refuse before latch write", int'(pumpEn), 0);

    arrWrite(5, 8'hA5);
    arrRead(9);
    check(cpuRdData == 8'hA5, "R8 latched read", int'(cpuRdData), 8'hA5);
    idleRead();

    regWrite(4'b1001);
    @(negedge clk);
    check(pumpEn, "R3 accept", int'(pumpEn), 1);
    arrRead(9);
    check(!arrRdAck && cpuRdData == 0, "R9 ignored read", int'(cpuRdData), 0);
    idleRead();

    regWrite(4'b1110);
    @(negedge clk);
    check(regRdData == 4'b1001, "R5 frozen bits", int'(regRdData), 9);
    arrWrite(12, 8'h5A);
    regWrite(4'b0000);
    @(negedge clk);
    check(regRdData == 4'b0001 && progData == 8'hA5, "R10 write during hv ignored",
          int'(progData), 8'hA5);

    regWrite(4'b0011);
    arrRead(33);
    check(cpuRdData == (8'd33 ^ 8'h3C), "R7 erase-select read", int'(cpuRdData), 33 ^ 8'h3C);
    idleRead();

    regWrite(4'b0010);
    regWrite(4'b0011);
    regWrite(4'b1011);
    @(negedge clk);
    check(!pumpEn, "R4 flag cleared by re-arm", int'(pumpEn), 0);

    arrWrite(20, 8'hC3);
    regWrite(4'b1010);
    @(negedge clk);
    check(!pumpEn && regRdData == 4'b0010, "R6 disarm with request", int'(regRdData), 2);
    arrRead(40);
    check(cpuRdData == (8'd40 ^ 8'h3C), "R7 normal read", int'(cpuRdData), 40 ^ 8'h3C);
    idleRead();

    arrWrite(60, 8'h11);
    @(negedge clk);
    check(progData == 8'hC3, "R10 write with latch off ignored", int'(progData), 8'hC3);

    regWrite(4'b0011);
    arrWrite(3, 8'h77);
    regWrite(4'b1011);
    @(negedge clk);
    check(pumpEn && eraseMode, "R3 erase accept", int'(pumpEn), 1);
    regWrite(4'b0011);
    @(negedge clk);
    check(!pumpEn && regRdData == 4'b0011, "R5 hv clear", int'(regRdData), 3);

    repeat (3) @(posedge clk);
    summary();
    $finish;
  end
endmodule